// File: doc/BRIEF.md
# HMAC Phase Sequencer

This block steers a keyed-hash message authentication through two nested passes of a single shared hash engine. The host configures the key type with an init strobe. It then streams the key, the message and the key a second time through one word-write port, and marks the final word of each with a last flag. The sequencer mixes each key word with the inner or outer pad constant and fills the key block up to a full 16-word block. Between the two passes it holds the inner digest and feeds it to the engine after the outer key block. A phase code and a ready flag tell the host which input is expected next.

In long-key mode the key is first hashed on its own. Its digest, zero-extended to a full block, then serves as the padded key. The compression engine is a simple non-cryptographic stub with a fixed latency, so that the sequencing can be checked exactly.

Top module: `hmac_phase_seq`

## Requirements
- R1: While reset is applied and after it is released, phase reads 0 (configure), wr_ready is 0 and res_valid is 0.
- R2: A high cfg_init in any state gives phase 0 on the next cycle, latches cfg_long_key, abandons any pass in progress and, one cycle later, enters inner-key entry (phase 1) with wr_ready high.
- R3: In short-key mode the key words K'[0..15] are the host key words followed by zeros. Words past the 16th are dropped. The inner pass hashes K'[i] XOR 32'h36363636 for i = 0..15, then the message words.
- R4: The outer pass hashes K'[i] XOR 32'h5C5C5C5C for i = 0..15, then the inner digest words 0..DIG_WORDS-1. Its digest is presented on res_digest with word j at bits [32j+31:32j].
- R5: In long-key mode each key entry is hashed as its own message. K'[i] is digest word i for i < DIG_WORDS and zero above that.
- R6: Phase encodes 0 configure, 1 inner key, 2 message, 3 outer key, 4 result. wr_ready is high only in phases 1 to 3 and only while host words are being taken. Message entry opens after the inner key block, and outer key entry opens after the inner digest is back.
- R7: A write offered while wr_ready is low is ignored and does not alter the result.
- R8: res_valid stays high and res_digest stays stable in the result phase until the next cfg_init.
- R9: The engine stub hashes words w0..w(n-1) as follows. s = 32'h67452301 XOR w0, then s = rotl1(s) XOR wi for each later word. Digest word j = (s + j) XOR n. The digest is ready ENG_LAT cycles after the final word.
- R10: A short key of exactly 16 words enters the engine with no filler words. A longer short key keeps only its first 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 1 | Start a new authentication, latch key type |
| cfg_long_key | input | 1 | 1 = key is hashed before use |
| wr_valid | input | 1 | Host word offered |
| wr_data | input | 32 | Host key or message word |
| wr_last | input | 1 | Marks final word of the current entry and starts processing |
| wr_ready | output | 1 | Host word is accepted this cycle |
| phase | output | 3 | Current phase code |
| res_valid | output | 1 | Authentication result available |
| res_digest | output | DIG_WORDS*32 | Final result |

## Verification
A wrong padding count or pad constant does not show until the result appears, one full outer pass later. The intermediate phase and ready transitions, however, show a sequencing slip within a few cycles of each last word. A wrong inner digest hold or a lost outer key block corrupts every result word, and these are compared against an independent model of the nested hash. Writes injected while the engine computes, and aborts issued mid-key, show any leakage as a digest mismatch on the next completed run.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;
  localparam logic [31:0] INNER_PAD = 32'h3636_3636;
  localparam logic [31:0] OUTER_PAD = 32'h5C5C_5C5C;

  typedef enum logic [2:0] {
    PH_CFG    = 3'd0,
    PH_IKEY   = 3'd1,
    PH_MSG    = 3'd2,
    PH_OKEY   = 3'd3,
    PH_RESULT = 3'd4
  } phase_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_KEY, ST_KWAIT, ST_PAD,
    ST_MSG, ST_IWAIT, ST_DFEED, ST_OWAIT, ST_DONE
  } seq_st_e;

  typedef enum logic [2:0] {
    SRC_HOST_RAW, SRC_HOST_PAD, SRC_ZERO_PAD, SRC_KDIG_PAD, SRC_IDIG
  } src_e;
endpackage

// File: rtl/hmac_digest_reg.sv
module hmac_digest_reg #(
  parameter int DIG_WORDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld,
  input  logic [DIG_WORDS*32-1:0] d,
  output logic [DIG_WORDS*32-1:0] q
);
  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else if (ld) w_q <= d[g*32 +: 32];
    end
    assign q[g*32 +: 32] = w_q;
  end
endmodule

// File: rtl/hmac_word_former.sv
module hmac_word_former
  import hmac_seq_pkg::*;
#(
  parameter int DIG_WORDS = 5,
  parameter int CW        = 5
) (
  input  src_e                    sel,
  input  logic                    outer,
  input  logic [31:0]             host,
  input  logic [DIG_WORDS*32-1:0] kdig,
  input  logic [DIG_WORDS*32-1:0] idig,
  input  logic [CW-1:0]           idx,
  output logic [31:0]             word
);
  logic [31:0] pad;
  logic [31:0] kw;
  logic [31:0] iw;

  assign pad = outer ? OUTER_PAD : INNER_PAD;

  // Indexed digest words; indices at or above DIG_WORDS read as zero.
  always_comb begin
    kw = '0;
    iw = '0;
    for (int j = 0; j < DIG_WORDS; j++) begin
      if (idx == CW'(j)) begin
        kw = kdig[j*32 +: 32];
        iw = idig[j*32 +: 32];
      end
    end
  end

  always_comb begin
    unique case (sel)
      SRC_HOST_RAW: word = host;
      SRC_HOST_PAD: word = host ^ pad;
      SRC_ZERO_PAD: word = pad;
      SRC_KDIG_PAD: word = kw ^ pad;
      SRC_IDIG:     word = iw;
      default:      word = host;
    endcase
  end
endmodule

// File: rtl/hmac_hash_stub.sv
module hmac_hash_stub #(
  parameter int          DIG_WORDS = 5,
  parameter int          ENG_LAT   = 4,
  parameter logic [31:0] IV        = 32'h6745_2301
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort,
  input  logic                    w_valid,
  input  logic                    w_new,
  input  logic                    w_fin,
  input  logic [31:0]             w_data,
  output logic                    done,
  output logic [DIG_WORDS*32-1:0] digest
);
  localparam int TW = $clog2(ENG_LAT + 1);

  logic [31:0]             st_q, st_n;
  logic [31:0]             cnt_q, cnt_n;
  logic [TW-1:0]           tmr_q, tmr_n;
  logic [DIG_WORDS*32-1:0] dig_q, dig_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (w_valid) begin
      if (w_new) begin
        st_n  = IV ^ w_data;
        cnt_n = 32'd1;
      end else begin
        st_n  = {st_q[30:0], st_q[31]} ^ w_data;
        cnt_n = cnt_q + 32'd1;
      end
    end
    for (int j = 0; j < DIG_WORDS; j++)
      dig_n[j*32 +: 32] = (st_n + 32'(j)) ^ cnt_n;
  end

  always_comb begin
    tmr_n = tmr_q;
    if (abort)                tmr_n = '0;
    else if (w_fin)           tmr_n = TW'(ENG_LAT);
    else if (tmr_q != '0)     tmr_n = tmr_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else if (w_valid) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_q <= '0;
    else if (w_fin) dig_q <= dig_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else tmr_q <= tmr_n;
  end

  assign done   = (tmr_q == TW'(1));
  assign digest = dig_q;

  // R9: the engine never receives a word while a digest is being computed
  a_r9_no_word_busy: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> (tmr_q == '0));
  // R9: finalisation always travels with a word
  a_r9_fin_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    w_fin |-> w_valid);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hmac_phase_seq.sv
module hmac_phase_seq
  import hmac_seq_pkg::*;
#(
  parameter int          DIG_WORDS   = 5,
  parameter int          BLOCK_WORDS = 16,
  parameter int          ENG_LAT     = 4,
  parameter logic [31:0] ENG_IV      = 32'h6745_2301
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_init,
  input  logic                    cfg_long_key,
  input  logic                    wr_valid,
  input  logic [31:0]             wr_data,
  input  logic                    wr_last,
  output logic                    wr_ready,
  output logic [2:0]              phase,
  output logic                    res_valid,
  output logic [DIG_WORDS*32-1:0] res_digest
);
  localparam int             DW       = DIG_WORDS * 32;
  localparam int             CW       = $clog2(BLOCK_WORDS + 1);
  localparam logic [CW-1:0]  FULL     = CW'(BLOCK_WORDS);
  localparam logic [CW-1:0]  LAST_BLK = CW'(BLOCK_WORDS - 1);
  localparam logic [CW-1:0]  LAST_DIG = CW'(DIG_WORDS - 1);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  seq_st_e       st_q, st_n;
  logic          pass_q, pass_n;    // 0 inner, 1 outer
  logic          long_q, long_n;
  logic          fresh_q, fresh_n;  // next engine word starts a new hash
  logic [CW-1:0] cnt_q, cnt_n;

  logic          eng_valid, eng_fin, eng_done;
  logic [31:0]   eng_word;
  logic [DW-1:0] eng_dig, kdig_q, idig_q;
  logic          ld_k, ld_i, ld_r;
  src_e          src;
  logic          accept;

  assign wr_ready = (st_q == ST_KEY) || (st_q == ST_MSG);
  assign accept   = wr_valid && wr_ready;

  // Next-state logic
  always_comb begin
    st_n      = st_q;
    pass_n    = pass_q;
    long_n    = long_q;
    fresh_n   = fresh_q;
    cnt_n     = cnt_q;
    eng_valid = 1'b0;
    eng_fin   = 1'b0;
    src       = SRC_HOST_RAW;
    ld_k      = 1'b0;
    ld_i      = 1'b0;
    ld_r      = 1'b0;

    unique case (st_q)
      ST_IDLE: ;
      ST_SETUP: begin
        st_n    = ST_KEY;
        pass_n  = 1'b0;
        fresh_n = 1'b1;
        cnt_n   = '0;
      end
      ST_KEY: if (accept) begin
        if (long_q) begin
          eng_valid = 1'b1;
          src       = SRC_HOST_RAW;
          if (wr_last) begin
            eng_fin = 1'b1;
            st_n    = ST_KWAIT;
          end
        end else begin
          if (cnt_q != FULL) begin
            eng_valid = 1'b1;
            src       = SRC_HOST_PAD;
            cnt_n     = cnt_q + CW'(1);
          end
          if (wr_last) begin
            if (cnt_n == FULL) begin
              st_n  = pass_q ? ST_DFEED : ST_MSG;
              cnt_n = '0;
            end else begin
              st_n = ST_PAD;
            end
          end
        end
      end
      ST_KWAIT: if (eng_done) begin
        ld_k    = 1'b1;
        cnt_n   = '0;
        fresh_n = 1'b1;
        st_n    = ST_PAD;
      end
      ST_PAD: begin
        eng_valid = 1'b1;
        src       = long_q ? SRC_KDIG_PAD : SRC_ZERO_PAD;
        cnt_n     = cnt_q + CW'(1);
        if (cnt_q == LAST_BLK) begin
          st_n  = pass_q ? ST_DFEED : ST_MSG;
          cnt_n = '0;
        end
      end
      ST_MSG: if (accept) begin
        eng_valid = 1'b1;
        src       = SRC_HOST_RAW;
        if (wr_last) begin
          eng_fin = 1'b1;
          st_n    = ST_IWAIT;
        end
      end
      ST_IWAIT: if (eng_done) begin
        ld_i    = 1'b1;
        pass_n  = 1'b1;
        fresh_n = 1'b1;
        cnt_n   = '0;
        st_n    = ST_KEY;
      end
      ST_DFEED: begin
        eng_valid = 1'b1;
        src       = SRC_IDIG;
        cnt_n     = cnt_q + CW'(1);
        if (cnt_q == LAST_DIG) begin
          eng_fin = 1'b1;
          st_n    = ST_OWAIT;
        end
      end
      ST_OWAIT: if (eng_done) begin
        ld_r = 1'b1;
        st_n = ST_DONE;
      end
      ST_DONE: ;
      default: st_n = ST_IDLE;
    endcase

    if (eng_valid) fresh_n = 1'b0;

    if (cfg_init) begin
      st_n   = ST_SETUP;
      long_n = cfg_long_key;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_IDLE;
      pass_q  <= 1'b0;
      long_q  <= 1'b0;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_n;
      pass_q  <= pass_n;
      long_q  <= long_n;
      fresh_q <= fresh_n;
      cnt_q   <= cnt_n;
    end
  end

  // Phase decode
  always_comb begin
    unique case (st_q)
      ST_KEY, ST_KWAIT, ST_PAD: phase = pass_q ? PH_OKEY : PH_IKEY;
      ST_MSG, ST_IWAIT:         phase = PH_MSG;
      ST_DFEED, ST_OWAIT:       phase = PH_OKEY;
      ST_DONE:                  phase = PH_RESULT;
      default:                  phase = PH_CFG;
    endcase
  end

  hmac_word_former #(.DIG_WORDS(DIG_WORDS), .CW(CW)) u_form (
    .sel  (src),
    .outer(pass_q),
    .host (wr_data),
    .kdig (kdig_q),
    .idig (idig_q),
    .idx  (cnt_q),
    .word (eng_word)
  );

  hmac_hash_stub #(.DIG_WORDS(DIG_WORDS), .ENG_LAT(ENG_LAT), .IV(ENG_IV)) u_eng (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .abort  (cfg_init),
    .w_valid(eng_valid),
    .w_new  (fresh_q),
    .w_fin  (eng_fin),
    .w_data (eng_word),
    .done   (eng_done),
    .digest (eng_dig)
  );

  hmac_digest_reg #(.DIG_WORDS(DIG_WORDS)) u_kdig (
    .clk(clk), .rst_n(rst_s_n), .ld(ld_k), .d(eng_dig), .q(kdig_q));
  hmac_digest_reg #(.DIG_WORDS(DIG_WORDS)) u_idig (
    .clk(clk), .rst_n(rst_s_n), .ld(ld_i), .d(eng_dig), .q(idig_q));
  hmac_digest_reg #(.DIG_WORDS(DIG_WORDS)) u_res (
    .clk(clk), .rst_n(rst_s_n), .ld(ld_r), .d(eng_dig), .q(res_digest));

  assign res_valid = (st_q == ST_DONE);

  // R2: init always lands in the configure phase
  a_r2_init_to_cfg: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_init |=> (phase == PH_CFG));
  // R6: host words are only taken in key or message phases
  a_r6_ready_phase: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_ready |-> (phase == PH_IKEY || phase == PH_MSG || phase == PH_OKEY));
  // R8: result holds until the next init
  a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    (res_valid && !cfg_init) |=> (res_valid && $stable(res_digest)));
  // R10: the key block counter never passes one full block
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_q <= FULL);
endmodule

// File: tb/hmac_phase_seq_tb.sv
module hmac_phase_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIGW       = 5;
  localparam int          DW         = DIGW * 32;
  localparam logic [31:0] IV         = 32'h6745_2301;
  localparam int          WD_LIMIT   = 150000;

  typedef struct packed {
    logic       lk;
    logic [5:0] kl;
    logic [5:0] ml;
    logic [15:0] sd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd4,  6'd3,  16'h1111},   // R3 short key, padded
    '{1'b0, 6'd16, 6'd1,  16'h2222},   // R10 exact block
    '{1'b1, 6'd20, 6'd5,  16'h3333},   // R5 long key
    '{1'b0, 6'd1,  6'd17, 16'h4444},   // R3 single key word
    '{1'b1, 6'd2,  6'd2,  16'h5555},   // R5 short long-mode key
    '{1'b0, 6'd18, 6'd4,  16'h6666}    // R10 extra words dropped
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_init, cfg_long_key;
  logic          wr_valid, wr_last;
  logic [31:0]   wr_data;
  logic          wr_ready;
  logic [2:0]    phase;
  logic          res_valid;
  logic [DW-1:0] res_digest;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] mb [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  hmac_phase_seq #(.DIG_WORDS(DIGW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_long_key(cfg_long_key),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .phase(phase), .res_valid(res_valid), .res_digest(res_digest)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got cycle %0d exp completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] keyw(input logic [15:0] sd, input int i);
    return {sd, 8'hC0, 8'(i)};
  endfunction
  function automatic logic [31:0] msgw(input logic [15:0] sd, input int i);
    return {~sd, 8'h3E, 8'(i)};
  endfunction

  // Model of the engine (R9) over mb[0..n-1]
  function automatic logic [DW-1:0] mhash(input int n);
    logic [31:0]   s;
    logic [DW-1:0] d;
    s = IV;
    for (int i = 0; i < n; i++)
      s = (i == 0) ? (IV ^ mb[i]) : ({s[30:0], s[31]} ^ mb[i]);
    for (int j = 0; j < DIGW; j++)
      d[j*32 +: 32] = (s + 32'(j)) ^ 32'(n);
    return d;
  endfunction

  function automatic logic [DW-1:0] model(input logic lk, input int kl, input int ml,
                                          input logic [15:0] sd);
    logic [31:0]   kp [16];
    logic [DW-1:0] kd, inr;
    kd = '0;
    if (lk) begin
      for (int i = 0; i < kl; i++) mb[i] = keyw(sd, i);
      kd = mhash(kl);
    end
    for (int i = 0; i < 16; i++) begin
      if (lk) kp[i] = (i < DIGW) ? kd[i*32 +: 32] : 32'h0;
      else    kp[i] = (i < kl) ? keyw(sd, i) : 32'h0;
    end
    for (int i = 0; i < 16; i++) mb[i] = kp[i] ^ 32'h3636_3636;
    for (int i = 0; i < ml; i++) mb[16+i] = msgw(sd, i);
    inr = mhash(16 + ml);
    for (int i = 0; i < 16; i++) mb[i] = kp[i] ^ 32'h5C5C_5C5C;
    for (int i = 0; i < DIGW; i++) mb[16+i] = inr[i*32 +: 32];
    return mhash(16 + DIGW);
  endfunction

  task automatic wait_ready();
    int g = 0;
    while (!wr_ready && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic put(input logic [31:0] w, input logic l);
    wait_ready();
    wr_valid = 1'b1; wr_data = w; wr_last = l;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic do_init(input logic lk);
    cfg_init = 1'b1; cfg_long_key = lk;
    @(negedge clk);
    cfg_init = 1'b0;
  endtask

  task automatic run(input vec_t v);
    logic [DW-1:0] exp;
    int g;
    exp = model(v.lk, int'(v.kl), int'(v.ml), v.sd);
    do_init(v.lk);
    for (int i = 0; i < int'(v.kl); i++) put(keyw(v.sd, i), i == int'(v.kl) - 1);
    wait_ready();
    chk("R6 message phase", DW'(phase), DW'(3'd2));
    for (int i = 0; i < int'(v.ml); i++) put(msgw(v.sd, i), i == int'(v.ml) - 1);
    // R7: junk offered while the inner digest is computed
    chk("R7 not ready in wait", DW'(wr_ready), DW'(1'b0));
    wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF; wr_last = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    wait_ready();
    chk("R6 outer key phase", DW'(phase), DW'(3'd3));
    for (int i = 0; i < int'(v.kl); i++) put(keyw(v.sd, i), i == int'(v.kl) - 1);
    g = 0;
    while (!res_valid && g < 4000) begin @(negedge clk); g++; end
    chk(v.lk ? "R5 long-key result" : "R3 R4 R10 short-key result R7", res_digest, exp);
    chk("R6 result phase", DW'(phase), DW'(3'd4));
  endtask

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0; cfg_init = 1'b0; cfg_long_key = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", DW'(phase), DW'(3'd0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 phase", DW'(phase), DW'(3'd0));
    chk("R1 ready", DW'(wr_ready), DW'(1'b0));
    chk("R1 valid", DW'(res_valid), DW'(1'b0));

    // Table-driven runs
    for (int k = 0; k < NV; k++) run(VECS[k]);

    // R8: result held, a write in the result phase is ignored
    held = res_digest;
    wr_valid = 1'b1; wr_data = 32'h1234_5678; wr_last = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 valid held", DW'(res_valid), DW'(1'b1));
    chk("R8 digest held", res_digest, held);

    // R2: abort mid inner key, then a clean run
    do_init(1'b0);
    put(32'hAAAA_0001, 1'b0);
    put(32'hAAAA_0002, 1'b0);
    cfg_init = 1'b1; cfg_long_key = 1'b1;
    @(negedge clk);
    cfg_init = 1'b0;
    chk("R2 cfg after init", DW'(phase), DW'(3'd0));
    @(negedge clk);
    chk("R2 inner key phase", DW'(phase), DW'(3'd1));
    chk("R2 ready", DW'(wr_ready), DW'(1'b1));
    chk("R2 valid cleared", DW'(res_valid), DW'(1'b0));
    run('{1'b0, 6'd3, 6'd2, 16'h7777});

    // R2: abort while engine busy in message wait
    do_init(1'b0);
    put(keyw(16'h8888, 0), 1'b1);
    wait_ready();
    put(msgw(16'h8888, 0), 1'b1);
    run('{1'b1, 6'd5, 6'd3, 16'h9999});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule